// File: doc/BRIEF.md
# Masked Interrupt Event Controller

This block collects the event flags of a network controller and turns them into interrupt requests. A 32-bit event register records which conditions have occurred; a 32-bit mask register selects which of them may interrupt. Hardware sets event bits with single-cycle pulses. Software reads both registers and writes the mask through a small register port, and it acknowledges an event by writing a one to its bit.

Thirteen of the event bits are wired out, each to its own interrupt line, in a fixed order. A line is asserted while its event bit and its mask bit are both one. A write to the transmit control address with bit 0 set requests a graceful stop. The stop completes at once, so the write raises the graceful-stop-done event directly.

Top module: `irq_event_ctrl`

## Requirements
- R1: Each event has a fixed bit position in the event register: underrun 19, retry limit 20, late collision 21, bus error 22, management done 23, receive buffer 24, receive frame 25, transmit buffer 26, transmit frame 27, graceful stop done 28, babbling transmit 29, babbling receive 30, heartbeat 31. A pulse on bit n of `evt_pulse_i` sets event bit n on the next clock edge.
- R2: A write to address 0 (event register) clears each event bit whose written data bit is 1. Every other bit keeps its value.
- R3: When a hardware pulse and a software clear target the same bit in the same cycle, the bit ends up set.
- R4: A write to address 1 (mask register) loads the whole 32-bit data word into the mask.
- R5: Output `irq_o[k]` is driven from event/mask bit pair S(k). For k = 0..12, S is 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30.
- R6: Each interrupt line is registered. It equals the AND of its event bit and mask bit as they stood one clock earlier.
- R7: A write to address 2 (transmit control) with data bit 0 = 1 sets event bit 28 on the next edge. With bit 0 = 0 the write changes nothing.
- R8: Reset, active high and synchronous, clears the event register, the mask register, all interrupt lines and the read data.
- R9: A read returns its data on `rdata_o` one cycle after `rd_en` is sampled. The data is the register value before any update in that same cycle. Address 2 and address 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 event, 1 mask, 2 transmit control |
| wdata | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after the read strobe |
| evt_pulse_i | input | 32 | Hardware event set pulses, one per event bit |
| irq_o | output | 13 | Dedicated interrupt lines |

## Verification
The hardest case to reach is a collision: a hardware set and a software write-one clear land on the same bit in the same cycle. The ordinary path never does this, because a clear follows the set by several cycles. The stimulus table includes a row that drives a full-word clear and a receive-frame pulse in one cycle, so the survivor can be seen both by read-back and on the interrupt line. A directed test reads the event register in the same cycle as a new pulse. It confirms that the read returns the value from before the update.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 2;
    localparam int NUM_LINES = 13;

    // event bit positions
    localparam int EV_UNDERRUN  = 19;
    localparam int EV_RETRY_LIM = 20;
    localparam int EV_LATE_COL  = 21;
    localparam int EV_BUS_ERR   = 22;
    localparam int EV_MGMT_DONE = 23;
    localparam int EV_RX_BUF    = 24;
    localparam int EV_RX_FRAME  = 25;
    localparam int EV_TX_BUF    = 26;
    localparam int EV_TX_FRAME  = 27;
    localparam int EV_GSTOP     = 28;
    localparam int EV_BABBLE_TX = 29;
    localparam int EV_BABBLE_RX = 30;
    localparam int EV_HEARTBEAT = 31;

    localparam logic [ADDR_W-1:0] ADR_EVT  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_MASK = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_TXC  = 2'd2;
    localparam int TXC_GSTOP_BIT = 0;

    typedef struct packed {
        logic [DATA_W-1:0] evt;
        logic [DATA_W-1:0] mask;
    } bank_t;

    // source event bit of each interrupt line; the order is fixed
    function automatic int line_src(input int idx);
        case (idx)
            0:       line_src = EV_TX_FRAME;
            1:       line_src = EV_TX_BUF;
            2:       line_src = EV_UNDERRUN;
            3:       line_src = EV_RETRY_LIM;
            4:       line_src = EV_RX_FRAME;
            5:       line_src = EV_RX_BUF;
            6:       line_src = EV_MGMT_DONE;
            7:       line_src = EV_LATE_COL;
            8:       line_src = EV_HEARTBEAT;
            9:       line_src = EV_GSTOP;
            10:      line_src = EV_BUS_ERR;
            11:      line_src = EV_BABBLE_TX;
            default: line_src = EV_BABBLE_RX;
        endcase
    endfunction
endpackage

// File: rtl/evt_reg_bank.sv
module evt_reg_bank
    import irq_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_evt,
    input  logic              wr_mask,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] set_vec,
    output logic [DATA_W-1:0] evt_q,
    output logic [DATA_W-1:0] mask_q
);
    bank_t bank_d, bank_q;
    logic [DATA_W-1:0] clr_vec;

    always_comb begin
        bank_d  = bank_q;
        clr_vec = wr_evt ? wdata : '0;
        // set is applied after clear so a colliding pulse survives
        bank_d.evt = (bank_q.evt & ~clr_vec) | set_vec;
        if (wr_mask) begin
            bank_d.mask = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign evt_q  = bank_q.evt;
    assign mask_q = bank_q.mask;
endmodule

// File: rtl/irq_line_map.sv
module irq_line_map
    import irq_evt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DATA_W-1:0]    evt,
    input  logic [DATA_W-1:0]    mask,
    output logic [NUM_LINES-1:0] irq_q
);
    logic [NUM_LINES-1:0] irq_d;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        localparam int SRC = line_src(i);
        always_comb begin
            irq_d[i] = evt[SRC] & mask[SRC];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end
endmodule

// File: rtl/reg_read_port.sv
module reg_read_port
    import irq_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] evt,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] rdata_q
);
    logic [DATA_W-1:0] rdata_d;

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en) begin
            case (addr)
                ADR_EVT:  rdata_d = evt;
                ADR_MASK: rdata_d = mask;
                default:  rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end
endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
    import irq_evt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata_o,
    input  logic [DATA_W-1:0]    evt_pulse_i,
    output logic [NUM_LINES-1:0] irq_o
);
    logic              wr_evt, wr_mask, gstop_req;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] evt_q, mask_q;

    always_comb begin
        wr_evt    = wr_en && (addr == ADR_EVT);
        wr_mask   = wr_en && (addr == ADR_MASK);
        gstop_req = wr_en && (addr == ADR_TXC) && wdata[TXC_GSTOP_BIT];
        set_vec   = evt_pulse_i;
        set_vec[EV_GSTOP] = evt_pulse_i[EV_GSTOP] | gstop_req;
    end

    evt_reg_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_evt  (wr_evt),
        .wr_mask (wr_mask),
        .wdata   (wdata),
        .set_vec (set_vec),
        .evt_q   (evt_q),
        .mask_q  (mask_q)
    );

    irq_line_map u_lines (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt_q),
        .mask  (mask_q),
        .irq_q (irq_o)
    );

    reg_read_port u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .addr    (addr),
        .evt     (evt_q),
        .mask    (mask_q),
        .rdata_q (rdata_o)
    );
endmodule

// File: rtl/irq_event_ctrl_chk.sv
module irq_event_ctrl_chk
    import irq_evt_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [DATA_W-1:0]    wdata,
    input logic [DATA_W-1:0]    rdata_o,
    input logic [DATA_W-1:0]    evt_pulse_i,
    input logic [NUM_LINES-1:0] irq_o,
    input logic [DATA_W-1:0]    evt_q,
    input logic [DATA_W-1:0]    mask_q
);
    assert_pulse_sets_R1: assert property (@(posedge clk) disable iff (rst)
        (|evt_pulse_i) |=> ((evt_q & $past(evt_pulse_i)) == $past(evt_pulse_i)));

    assert_clear_ones_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADR_EVT && evt_pulse_i == '0) |=> ((evt_q & $past(wdata)) == '0));

    assert_keep_unwritten_R2: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && evt_pulse_i == '0) |=> $stable(evt_q));

    assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADR_EVT && (wdata & evt_pulse_i) != '0)
        |=> ((evt_q & $past(wdata & evt_pulse_i)) == $past(wdata & evt_pulse_i)));

    assert_mask_load_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADR_MASK) |=> (mask_q == $past(wdata)));

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_irq
        localparam int SRC = line_src(i);
        assert_line_delay_R6: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (irq_o[i] == $past(evt_q[SRC] & mask_q[SRC])));
    end

    assert_gstop_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADR_TXC && wdata[TXC_GSTOP_BIT]) |=> evt_q[EV_GSTOP]);

    assert_read_evt_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADR_EVT) |=> (rdata_o == $past(evt_q)));

    assert_read_mask_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADR_MASK) |=> (rdata_o == $past(mask_q)));
endmodule

bind irq_event_ctrl irq_event_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata_o     (rdata_o),
    .evt_pulse_i (evt_pulse_i),
    .irq_o       (irq_o),
    .evt_q       (evt_q),
    .mask_q      (mask_q)
);

// File: tb/tb_irq_event_ctrl.sv
module tb_irq_event_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en;
    logic [1:0]  addr;
    logic [31:0] wdata, evt_pulse_i, rdata_o;
    logic [12:0] irq_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    irq_event_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata_o(rdata_o), .evt_pulse_i(evt_pulse_i), .irq_o(irq_o)
    );

    // line order from R5
    localparam int SRC_TB [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

    typedef struct packed {
        logic        wr;
        logic [1:0]  adr;
        logic [31:0] data;
        logic [31:0] pulse;
        logic [31:0] exp_evt;
        logic [31:0] exp_mask;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd1, 32'hFFFF_FFFF, 32'h0,         32'h0,         32'hFFFF_FFFF}, // R4
        '{1'b0, 2'd0, 32'h0,         32'h0800_0000, 32'h0800_0000, 32'hFFFF_FFFF}, // R1
        '{1'b0, 2'd0, 32'h0,         32'h8008_0000, 32'h8808_0000, 32'hFFFF_FFFF}, // R1
        '{1'b1, 2'd0, 32'h0800_0000, 32'h0,         32'h8008_0000, 32'hFFFF_FFFF}, // R2
        '{1'b1, 2'd1, 32'h0008_0000, 32'h0,         32'h8008_0000, 32'h0008_0000}, // R4
        '{1'b1, 2'd2, 32'h0000_0001, 32'h0,         32'h9008_0000, 32'h0008_0000}, // R7
        '{1'b1, 2'd2, 32'h0000_0002, 32'h0,         32'h9008_0000, 32'h0008_0000}, // R7
        '{1'b1, 2'd1, 32'hFFF8_0000, 32'h0,         32'h9008_0000, 32'hFFF8_0000}, // R5
        '{1'b1, 2'd0, 32'hFFFF_FFFF, 32'h0200_0000, 32'h0200_0000, 32'hFFF8_0000}, // R3
        '{1'b0, 2'd0, 32'h0,         32'h7FF8_0000, 32'h7FF8_0000, 32'hFFF8_0000}, // R5
        '{1'b1, 2'd0, 32'h0,         32'h0,         32'h7FF8_0000, 32'hFFF8_0000}, // R2
        '{1'b0, 2'd0, 32'h0,         32'h0000_FFFF, 32'h7FF8_FFFF, 32'hFFF8_0000}, // R1
        '{1'b1, 2'd1, 32'h0,         32'h0,         32'h7FF8_FFFF, 32'h0}          // R6
    };

    function automatic logic [12:0] exp_lines(input logic [31:0] e, input logic [31:0] m);
        logic [12:0] r;
        for (int k = 0; k < 13; k++) r[k] = e[SRC_TB[k]] & m[SRC_TB[k]];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; addr = 0; wdata = 0; evt_pulse_i = 0;
    endtask

    // read through the port; result checked one edge later (R9)
    task automatic read_check(input logic [1:0] a, input logic [31:0] exp, input string req);
        idle(); rd_en = 1; addr = a;
        @(negedge clk);
        check(req, rdata_o, exp);
        idle();
    endtask

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        // reset state (R8)
        check("R8 irq", {19'd0, irq_o}, 32'h0);
        check("R8 rdata", rdata_o, 32'h0);
        rst = 0;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            wr_en = VEC[v].wr; addr = VEC[v].adr; wdata = VEC[v].data;
            evt_pulse_i = VEC[v].pulse;
            @(negedge clk);
            idle(); rd_en = 1; addr = 2'd0;
            @(negedge clk);
            check($sformatf("R2/R3/R7 evt vec%0d", v), rdata_o, VEC[v].exp_evt);
            // R5 R6: lines reflect event AND mask from the previous edge
            check($sformatf("R5/R6 irq vec%0d", v), {19'd0, irq_o},
                  {19'd0, exp_lines(VEC[v].exp_evt, VEC[v].exp_mask)});
            addr = 2'd1;
            @(negedge clk);
            check($sformatf("R4 mask vec%0d", v), rdata_o, VEC[v].exp_mask);
            idle();
        end

        // R6: line rises exactly one edge after the event bit
        idle(); wr_en = 1; addr = 2'd1; wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        idle(); wr_en = 1; addr = 2'd0; wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        idle(); evt_pulse_i = 32'h4000_0000;
        @(negedge clk);
        idle();
        check("R6 line12 not yet", {31'd0, irq_o[12]}, 32'd0);
        @(negedge clk);
        check("R6 line12 raised", {31'd0, irq_o[12]}, 32'd1);

        // R9: read in same cycle as a pulse returns the older value
        idle(); rd_en = 1; addr = 2'd0; evt_pulse_i = 32'h0010_0000;
        @(negedge clk);
        check("R9 read before update", rdata_o, 32'h4000_0000);
        read_check(2'd0, 32'h4010_0000, "R9 read after update");
        read_check(2'd2, 32'h0, "R9 txctl reads zero");
        read_check(2'd3, 32'h0, "R9 addr3 reads zero");

        // R8: reset mid-run clears everything
        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R8 irq after reset", {19'd0, irq_o}, 32'h0);
        read_check(2'd0, 32'h0, "R8 evt after reset");
        read_check(2'd1, 32'h0, "R8 mask after reset");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule